// File: doc/BRIEF.md
# Factory Bad-Block Scanner

This block builds the bad-block table of a NAND array when the system starts. After a start pulse it visits every erase block in ascending order. For each one it asks a page-read port for a single byte: the first spare-area byte of the block's first page. It stores one bit per block in a local RAM, where 1 means bad. It also keeps a running total of bad blocks and raises a fault flag once that total goes beyond the permitted number.

After the walk, the table serves three clients. A lookup port returns the bit of any block one cycle after the index is presented. A host can add a block to the table at run time when a program or erase on that block has failed. An erase gate answers every erase request with a grant or a refusal. A bad block is always refused, so its factory marker can never be wiped. The scanner issues no erase of its own, and it does no NAND bus sequencing: the read port is a plain valid/ready request with a one-beat response.

Top module: `factory_bbt_scan`

## Requirements
- R1: A start pulse while idle begins a walk; a start while a walk runs is ignored. The walk requests blocks 0 to BLOCKS-1 in order, one request at a time. The row is the block index shifted left by 6 with the six page bits zero, and the column is 2048. `rd_req_valid` and the row stay fixed until `rd_req_ready` is high on a clock edge.
- R2: A response byte of 00h sets the block's table bit to 1 (bad). Any other value sets it to 0 (good), including FFh, F0h and 01h.
- R3: `scan_busy` is high from the edge that accepts start through the edge that takes the last block's response. On that edge `scan_busy` falls and `scan_done` is high for exactly one cycle.
- R4: `bad_count` returns to 0 on the edge that accepts start. It rises by one on the edge of each 00h response, and by one on each host mark that makes a good block bad.
- R5: `dev_fault` is 1 exactly when `bad_count` exceeds BAD_LIMIT (40 by default). It changes on the same edge as the count and is cleared by start.
- R6: `look_bad` shows the table bit of the `look_block` sampled on the previous edge.
- R7: A mark is accepted only when no walk runs, at least one walk has completed, and no start is present on the same edge. An accepted mark of a good block sets its bit and raises `bad_count` one edge later. A mark of a block already bad leaves the count unchanged, even for back-to-back marks of one block. Marks that are not accepted have no effect.
- R8: Each `erase_valid` sampled on an edge is answered on the next edge by exactly one of `erase_ok` and `erase_deny`, each a one-cycle pulse. A deny is given when any of these holds: the block is bad (counting marks accepted on the same edge or the edge before), a walk runs, no walk has completed, or start is present.
- R9: After reset, `scan_busy`, `scan_done`, `rd_req_valid`, `erase_ok`, `erase_deny` and `dev_fault` are 0, and `bad_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a walk of all blocks |
| rd_req_valid | output | 1 | Read request pending |
| rd_req_row | output | 17 | Row address: block index followed by six zero page bits |
| rd_req_col | output | 12 | Column of the marker byte (2048) |
| rd_req_ready | input | 1 | Read port accepts the request |
| rd_rsp_valid | input | 1 | Marker byte is present |
| rd_rsp_data | input | 8 | Marker byte |
| scan_busy | output | 1 | Walk in progress |
| scan_done | output | 1 | One-cycle pulse after the last block |
| bad_count | output | 12 | Number of blocks in the table marked bad |
| dev_fault | output | 1 | Count exceeds the permitted limit |
| look_block | input | 11 | Block index to look up |
| look_bad | output | 1 | Table bit of the block looked up one cycle earlier |
| mark_valid | input | 1 | Host marks a block bad |
| mark_block | input | 11 | Block to mark |
| erase_valid | input | 1 | Erase permission request |
| erase_block | input | 11 | Block to be erased |
| erase_ok | output | 1 | Erase granted |
| erase_deny | output | 1 | Erase refused |

## Verification
The hardest case to reach is a host mark still in flight: its table write has not landed when a second mark or an erase check for the same block reads the RAM. The stimulus drives two marks of one block on consecutive edges, then pairs a mark with an erase of the same block on the same edge and on the following edge. The result is seen through `bad_count`, `erase_deny` and `look_bad`. Start is also raised on the same edge as a mark, to show the mark has no lasting effect after the rescan.

// File: rtl/fbbt_pkg.sv
package fbbt_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_ISSUE = 2'd1,
    WALK_WAIT  = 2'd2
  } walk_state_t;
endpackage

// File: rtl/fbbt_bitram.sv
module fbbt_bitram #(
  parameter int DEPTH = 2048,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic            wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD-1:0]  rdata
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_ff @(posedge clk) begin
      rdata[g] <= mem[raddr[g*AW +: AW]];
    end
  end
endmodule

// File: rtl/fbbt_walker.sv
module fbbt_walker
  import fbbt_pkg::*;
#(
  parameter int          BLOCKS   = 2048,
  parameter int          PG_W     = 6,
  parameter logic [7:0]  BAD_CODE = 8'h00,
  localparam int         BLK_W    = $clog2(BLOCKS),
  localparam int         ROW_W    = BLK_W + PG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             last_wr,
  output logic             req_valid,
  output logic [ROW_W-1:0] req_row,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic [7:0]       rsp_data,
  output logic             wr_en,
  output logic [BLK_W-1:0] wr_addr,
  output logic             wr_bad,
  output logic             inc
);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLOCKS - 1);

  walk_state_t      state;
  logic [BLK_W-1:0] blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WALK_IDLE;
      blk   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        WALK_IDLE: begin
          if (start) begin
            blk   <= '0;
            state <= WALK_ISSUE;
          end
        end
        WALK_ISSUE: begin
          if (req_ready) state <= WALK_WAIT;
        end
        WALK_WAIT: begin
          if (rsp_valid) begin
            if (blk == LAST_BLK) begin
              done  <= 1'b1;
              state <= WALK_IDLE;
            end else begin
              blk   <= blk + 1'b1;
              state <= WALK_ISSUE;
            end
          end
        end
        default: state <= WALK_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != WALK_IDLE);
    req_valid = (state == WALK_ISSUE);
    req_row   = {blk, {PG_W{1'b0}}};
    wr_en     = (state == WALK_WAIT) && rsp_valid;
    wr_addr   = blk;
    wr_bad    = (rsp_data == BAD_CODE);
    inc       = wr_en && wr_bad;
    last_wr   = wr_en && (blk == LAST_BLK);
  end

  a_r1_req_held: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_row)));
  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r3_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r1_start_ignored_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_en) |=> (busy && $stable(blk)) || $changed(state));
endmodule

// File: rtl/fbbt_tally.sv
module fbbt_tally #(
  parameter int BLOCKS    = 2048,
  parameter int BAD_LIMIT = 40,
  localparam int CNT_W    = $clog2(BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc_scan,
  input  logic             inc_host,
  output logic [CNT_W-1:0] count,
  output logic             fault
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(BAD_LIMIT);

  logic [CNT_W-1:0] count_nxt;

  always_comb begin
    count_nxt = count + CNT_W'(inc_scan) + CNT_W'(inc_host);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
      fault <= 1'b0;
    end else begin
      count <= count_nxt;
      fault <= (count_nxt > LIM_V);
    end
  end

  a_r4_single_source: assert property (@(posedge clk) disable iff (rst)
    !(inc_scan && inc_host));
  a_r4_no_decrease: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (count >= $past(count)));
  a_r5_fault_tracks: assert property (@(posedge clk) disable iff (rst)
    fault == (count > LIM_V));
endmodule

// File: rtl/fbbt_hostgate.sv
module fbbt_hostgate #(
  parameter int BLOCKS = 2048,
  localparam int BLK_W = $clog2(BLOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             busy,
  input  logic             table_ok,
  input  logic             mark_valid,
  input  logic [BLK_W-1:0] mark_block,
  input  logic             erase_valid,
  input  logic [BLK_W-1:0] erase_block,
  input  logic             rd_mark,
  input  logic             rd_erase,
  output logic             wr_en,
  output logic [BLK_W-1:0] wr_addr,
  output logic             inc,
  output logic             erase_ok,
  output logic             erase_deny
);
  logic             accept;
  logic             s1_v;
  logic [BLK_W-1:0] s1_b;
  logic             s1_fwd;
  logic             e_v;
  logic             e_pre;
  logic             e_hit;
  logic             e_bad;

  always_comb begin
    accept  = mark_valid && !busy && table_ok && !start;
    wr_en   = s1_v && !(rd_mark || s1_fwd) && !start;
    wr_addr = s1_b;
    inc     = wr_en;
    e_bad   = e_pre || e_hit || rd_erase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v       <= 1'b0;
      s1_b       <= '0;
      s1_fwd     <= 1'b0;
      e_v        <= 1'b0;
      e_pre      <= 1'b0;
      e_hit      <= 1'b0;
      erase_ok   <= 1'b0;
      erase_deny <= 1'b0;
    end else begin
      s1_v       <= accept;
      s1_b       <= mark_block;
      s1_fwd     <= s1_v && (s1_b == mark_block);
      e_v        <= erase_valid;
      e_pre      <= busy || !table_ok || start;
      e_hit      <= (accept && (mark_block == erase_block)) ||
                    (s1_v && (s1_b == erase_block));
      erase_ok   <= e_v && !e_bad;
      erase_deny <= e_v && e_bad;
    end
  end

  a_r8_one_answer: assert property (@(posedge clk) disable iff (rst)
    !(erase_ok && erase_deny));
  a_r8_answered: assert property (@(posedge clk) disable iff (rst)
    erase_valid |=> ##1 (erase_ok || erase_deny));
  a_r7_no_write_in_walk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !busy);
  a_r8_busy_denied: assert property (@(posedge clk) disable iff (rst)
    (erase_valid && busy) |=> ##1 erase_deny);
endmodule

// File: rtl/factory_bbt_scan.sv
module factory_bbt_scan #(
  parameter int         BLOCKS          = 2048,
  parameter int         PAGES_PER_BLOCK = 64,
  parameter int         PAGE_BYTES      = 2048,
  parameter int         BAD_LIMIT       = 40,
  parameter logic [7:0] BAD_CODE        = 8'h00,
  localparam int        BLK_W           = $clog2(BLOCKS),
  localparam int        PG_W            = $clog2(PAGES_PER_BLOCK),
  localparam int        ROW_W           = BLK_W + PG_W,
  localparam int        COL_W           = $clog2(PAGE_BYTES) + 1,
  localparam int        CNT_W           = $clog2(BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             rd_req_valid,
  output logic [ROW_W-1:0] rd_req_row,
  output logic [COL_W-1:0] rd_req_col,
  input  logic             rd_req_ready,
  input  logic             rd_rsp_valid,
  input  logic [7:0]       rd_rsp_data,
  output logic             scan_busy,
  output logic             scan_done,
  output logic [CNT_W-1:0] bad_count,
  output logic             dev_fault,
  input  logic [BLK_W-1:0] look_block,
  output logic             look_bad,
  input  logic             mark_valid,
  input  logic [BLK_W-1:0] mark_block,
  input  logic             erase_valid,
  input  logic [BLK_W-1:0] erase_block,
  output logic             erase_ok,
  output logic             erase_deny
);
  localparam int NRD = 3;

  logic             w_busy;
  logic             w_last;
  logic             w_we;
  logic [BLK_W-1:0] w_addr;
  logic             w_bad;
  logic             w_inc;
  logic             h_we;
  logic [BLK_W-1:0] h_addr;
  logic             h_inc;
  logic             table_ok;
  logic             start_acc;
  logic             ram_we;
  logic [BLK_W-1:0] ram_waddr;
  logic             ram_wdata;
  logic [NRD-1:0]   ram_rd;

  always_comb begin
    start_acc = start && !w_busy;
    ram_we    = w_we || h_we;
    ram_waddr = w_we ? w_addr : h_addr;
    ram_wdata = w_we ? w_bad : 1'b1;
    scan_busy = w_busy;
    look_bad  = ram_rd[0];
    rd_req_col = COL_W'(PAGE_BYTES);
  end

  always_ff @(posedge clk) begin
    if (rst) table_ok <= 1'b0;
    else if (w_last) table_ok <= 1'b1;
  end

  fbbt_walker #(
    .BLOCKS(BLOCKS), .PG_W(PG_W), .BAD_CODE(BAD_CODE)
  ) u_walker (
    .clk(clk), .rst(rst), .start(start),
    .busy(w_busy), .done(scan_done), .last_wr(w_last),
    .req_valid(rd_req_valid), .req_row(rd_req_row), .req_ready(rd_req_ready),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data),
    .wr_en(w_we), .wr_addr(w_addr), .wr_bad(w_bad), .inc(w_inc)
  );

  fbbt_hostgate #(.BLOCKS(BLOCKS)) u_hostgate (
    .clk(clk), .rst(rst), .start(start), .busy(w_busy), .table_ok(table_ok),
    .mark_valid(mark_valid), .mark_block(mark_block),
    .erase_valid(erase_valid), .erase_block(erase_block),
    .rd_mark(ram_rd[1]), .rd_erase(ram_rd[2]),
    .wr_en(h_we), .wr_addr(h_addr), .inc(h_inc),
    .erase_ok(erase_ok), .erase_deny(erase_deny)
  );

  fbbt_tally #(.BLOCKS(BLOCKS), .BAD_LIMIT(BAD_LIMIT)) u_tally (
    .clk(clk), .rst(rst), .clr(start_acc),
    .inc_scan(w_inc), .inc_host(h_inc),
    .count(bad_count), .fault(dev_fault)
  );

  fbbt_bitram #(.DEPTH(BLOCKS), .NRD(NRD)) u_table (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr({erase_block, mark_block, look_block}), .rdata(ram_rd)
  );

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!scan_busy && !scan_done && !rd_req_valid && bad_count == '0));
  a_r3_busy_until_done: assert property (@(posedge clk) disable iff (rst)
    $fell(scan_busy) |-> scan_done);
endmodule

// File: tb/factory_bbt_scan_bench.sv
module factory_bbt_scan_bench;
  localparam int NB  = 2048;
  localparam int LIM = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd_req_valid;
  logic [16:0] rd_req_row;
  logic [11:0] rd_req_col;
  logic        rd_req_ready = 1'b0;
  logic        rd_rsp_valid = 1'b0;
  logic [7:0]  rd_rsp_data = 8'hFF;
  logic        scan_busy, scan_done, dev_fault, look_bad, erase_ok, erase_deny;
  logic [11:0] bad_count;
  logic [10:0] look_block = '0;
  logic        mark_valid = 1'b0;
  logic [10:0] mark_block = '0;
  logic        erase_valid = 1'b0;
  logic [10:0] erase_block = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int pat = 0;

  always #4 clk = ~clk;

  factory_bbt_scan u_factory_bbt_scan (
    .clk(clk), .rst(rst), .start(start),
    .rd_req_valid(rd_req_valid), .rd_req_row(rd_req_row), .rd_req_col(rd_req_col),
    .rd_req_ready(rd_req_ready), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .scan_busy(scan_busy), .scan_done(scan_done), .bad_count(bad_count),
    .dev_fault(dev_fault), .look_block(look_block), .look_bad(look_bad),
    .mark_valid(mark_valid), .mark_block(mark_block),
    .erase_valid(erase_valid), .erase_block(erase_block),
    .erase_ok(erase_ok), .erase_deny(erase_deny)
  );

  function automatic logic [7:0] marker(int b);
    if (pat == 0) begin
      if ((b % 51 == 3 && b < 1990) || b == NB - 1) return 8'h00;
      if (b % 7 == 0) return 8'hF0;
      if (b % 11 == 0) return 8'h01;
      return 8'hFF;
    end
    return (b % 45 == 0) ? 8'h00 : 8'hFF;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  bit m_logic [NB];
  bit m_phys  [NB];
  int m_count;
  bit m_busy, m_done, m_valid, m_fault, m_look, m_eok, m_edeny, q_eok, q_edeny;
  bit pend_wr;
  int pend_blk;
  int rsp_blk;

  always @(posedge clk) begin
    if (rst) begin
      m_count = 0; m_busy = 0; m_done = 0; m_valid = 0; m_fault = 0;
      m_eok = 0; m_edeny = 0; q_eok = 0; q_edeny = 0; pend_wr = 0;
    end else begin
      bit st;
      bit deny;
      st = start && !m_busy;
      m_done = 0;
      m_look = m_phys[look_block];
      m_eok = q_eok; m_edeny = q_edeny; q_eok = 0; q_edeny = 0;
      if (pend_wr && !st) begin
        m_phys[pend_blk] = 1;
        m_count++;
      end
      pend_wr = 0;
      if (mark_valid && !m_busy && m_valid && !st && !m_logic[mark_block]) begin
        m_logic[mark_block] = 1;
        pend_wr = 1;
        pend_blk = mark_block;
      end
      if (erase_valid) begin
        deny = st || m_busy || !m_valid || m_logic[erase_block];
        q_eok = !deny;
        q_edeny = deny;
      end
      if (rd_rsp_valid && m_busy) begin
        bit bad;
        bad = (rd_rsp_data == 8'h00);
        m_phys[rsp_blk] = bad;
        m_logic[rsp_blk] = bad;
        if (bad) m_count++;
        if (rsp_blk == NB - 1) begin
          m_busy = 0; m_done = 1; m_valid = 1;
        end
      end
      if (st) begin
        m_busy = 1;
        m_count = 0;
      end
      m_fault = (m_count > LIM);
    end
  end

  // per-cycle comparison, then the read-port responder
  int exp_blk = 0;
  int cyc = 0;
  bit rpend = 0;
  int rdly = 0;
  int rblk = 0;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R3 scan_busy", scan_busy, m_busy);
      chk("R3 scan_done", scan_done, m_done);
      chk("R4 bad_count", bad_count, m_count);
      chk("R5 dev_fault", dev_fault, m_fault);
      chk("R8 erase_ok", erase_ok, m_eok);
      chk("R8 erase_deny", erase_deny, m_edeny);
      if (m_valid) chk("R6 look_bad", look_bad, m_look);
      if (!m_busy) chk("R1 no request when idle", rd_req_valid, 0);
    end
    if (rd_rsp_valid) rd_rsp_valid = 1'b0;
    if (rpend) begin
      if (rdly == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data = marker(rblk);
        rsp_blk = rblk;
        rpend = 0;
      end else rdly--;
    end
    rd_req_ready = (cyc % 3) != 2;
    cyc++;
    if (!rst && rd_req_valid && rd_req_ready) begin
      chk("R1 row", rd_req_row, exp_blk << 6);
      chk("R1 column", rd_req_col, 2048);
      rblk = rd_req_row >> 6;
      rpend = 1;
      rdly = rblk % 3;
      exp_blk = (exp_blk + 1) % NB;
    end
  end

  task automatic do_mark(int b);
    mark_valid = 1'b1; mark_block = 11'(b);
    @(negedge clk);
    mark_valid = 1'b0;
  endtask

  task automatic do_erase(int b, bit exp_ok, string tag);
    erase_valid = 1'b1; erase_block = 11'(b);
    @(negedge clk);
    erase_valid = 1'b0;
    @(negedge clk);
    chk(tag, {erase_ok, erase_deny}, exp_ok ? 2'b10 : 2'b01);
  endtask

  task automatic do_look(int b, bit exp, string tag);
    look_block = 11'(b);
    @(negedge clk);
    chk(tag, look_bad, exp);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=running expected=idle");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 busy", scan_busy, 0);
    chk("R9 done", scan_done, 0);
    chk("R9 count", bad_count, 0);
    chk("R9 fault", dev_fault, 0);
    chk("R9 erase outputs", {erase_ok, erase_deny}, 0);
    chk("R9 request", rd_req_valid, 0);
    // before any walk: erase refused, mark ignored
    do_erase(5, 0, "R8 deny before walk");
    do_mark(9);
    repeat (3) @(negedge clk);
    chk("R7 mark ignored before walk", bad_count, 0);

    pat = 0;
    pulse_start();
    repeat (6) @(negedge clk);
    pulse_start();                       // R1 ignored while busy
    do_mark(3);                          // R7 ignored while busy
    do_erase(100, 0, "R8 deny during walk");
    wait_idle();
    chk("R4 count after walk", bad_count, 40);
    chk("R5 no fault at limit", dev_fault, 0);
    do_look(3, 1, "R2 marker 00h bad");
    do_look(NB - 1, 1, "R2 last block bad");
    do_look(54, 1, "R2 marker 00h bad");
    do_look(7, 0, "R2 marker F0h good");
    do_look(11, 0, "R2 marker 01h good");
    do_look(1, 0, "R2 marker FFh good");
    do_erase(1, 1, "R8 grant good block");
    do_erase(54, 0, "R8 deny bad block");

    do_mark(5);
    @(negedge clk);
    chk("R7 mark raises count", bad_count, 41);
    chk("R5 fault above limit", dev_fault, 1);
    // back-to-back marks of one block count once
    mark_valid = 1'b1; mark_block = 11'd6;
    @(negedge clk);
    @(negedge clk);
    mark_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 repeated mark counted once", bad_count, 42);
    do_mark(5);
    repeat (2) @(negedge clk);
    chk("R7 already bad unchanged", bad_count, 42);
    // mark and erase of one block on the same edge
    mark_valid = 1'b1; mark_block = 11'd8;
    erase_valid = 1'b1; erase_block = 11'd8;
    @(negedge clk);
    mark_valid = 1'b0; erase_valid = 1'b0;
    @(negedge clk);
    chk("R8 deny same-edge mark", {erase_ok, erase_deny}, 2'b01);
    // erase one edge after the mark
    do_mark(12);
    do_erase(12, 0, "R8 deny mark in flight");
    do_look(6, 1, "R7 mark visible in lookup");

    // second walk; a mark on the start edge is ignored
    pat = 1;
    start = 1'b1; mark_valid = 1'b1; mark_block = 11'd10;
    @(negedge clk);
    start = 1'b0; mark_valid = 1'b0;
    wait_idle();
    chk("R4 count restarted", bad_count, 46);
    chk("R5 fault from walk", dev_fault, 1);
    do_look(10, 0, "R7 start-edge mark ignored");
    do_look(45, 1, "R2 second pattern bad");
    do_erase(10, 1, "R8 grant after rescan");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule